// File: doc/BRIEF.md
# Shared-Prescaler Tick Generator for a Five-Channel Timer Bank

This block turns one peripheral clock into five count-enable strobes, one for each timer channel. Two 8-bit prescalers divide the clock first. The first prescaler feeds channels 0 and 1. The second feeds channels 2, 3 and 4. After its prescaler, each channel has its own power-of-two divider. The channel counters that sit downstream advance only in the cycles where their strobe is high. Every output is a plain enable in the one clock domain, so the clock is never gated.

Software sets the block up through a small register port that holds two words. Word 0 holds both prescaler values. Word 1 holds a 4-bit divider code for each channel. Each channel ticks at `clk / ((P+1) * 2^(code + DIV_BASE))`, where P is the stored value of the channel's prescaler. The parameter `DIV_BASE` covers the two field encodings in use: when it is 1, code 0 means divide-by-2; when it is 0, code 0 means divide-by-1.

Top module: `tick_prescale_bank`

## Requirements
- R1: While reset is low, and at the first clock edge after it, every `ch_tick` bit is 0. After reset both configuration words read back as 0.
- R2: Writing address 0 stores bits 15:0 of `reg_wdata`. Writing address 1 stores bits 19:0. `reg_rdata` returns the stored word of the address in `reg_addr` in the same cycle, and reads 0 in every bit above the stored field.
- R3: A stored prescaler value P makes that prescaler pulse once every P+1 clocks. The channel tick period is then (P+1) × divisor clocks.
- R4: Channels 0 and 1 take their pulses from prescaler 0 (word 0, bits 7:0). Channels 2, 3 and 4 take theirs from prescaler 1 (word 0, bits 15:8). A channel never ticks unless its prescaler pulsed in the previous cycle.
- R5: The divider code for channel c sits in word 1, bits 4c+3:4c. It selects divisor 2^(code + DIV_BASE). The default DIV_BASE is 1.
- R6: A code whose exponent would exceed MAX_LOG2 (default 4) saturates at divisor 2^MAX_LOG2.
- R7: Each tick lasts exactly one clock whenever the divisor is greater than 1.
- R8: Any write to address 1 restarts the phase of every channel's divider. No tick appears in the cycle after the write. The first tick comes after a full divisor's worth of new prescaler pulses.
- R9: A new prescaler value does not cut short the countdown already running. It is loaded only at that prescaler's next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the configuration port |
| reg_addr | input | 1 | Word select for reads and writes (0 = prescalers, 1 = divider codes) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| ch_tick | output | 5 | One-cycle count-enable strobe for each channel |

## Verification
A wrong prescaler count shows up as a wrong tick spacing on every channel that shares that prescaler. Within one tick period, channels 0–1 and channels 2–4 drift apart from the expected (P+1) × divisor spacing as a group. A divider phase that is stuck or not restarted shows on one channel alone. It appears either as a tick in the cycle right after a word-1 write, or as a first tick too early or too late against the bounds set by the prescaler period. An early reload of the prescaler is visible as a tick that arrives within a few clocks of reprogramming, where the bench expects it only after the old countdown has run out.

// File: rtl/tick_prescale_pkg.sv
// Shared constants and helpers for the tick prescale bank.
// Assumes: exponents are small non-negative integers.
package tick_prescale_pkg;

    // Address of the prescaler word and of the divider-code word
    localparam logic ADDR_PRESCALE = 1'b0;
    localparam logic ADDR_DIVSEL   = 1'b1;

    // Effective log2 of the divisor: code plus base, saturated at the maximum
    function automatic int eff_log2(input int code, input int base, input int max_log2);
        int s;
        s = code + base;
        return (s > max_log2) ? max_log2 : s;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Free-running down counter that pulses for one cycle when it reaches zero
// and then reloads the preset value. A new preset is taken only at a reload.
// Assumes: the preset is held in a register outside this module.
module tick_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] preset,
    output logic            pulse
);

    logic [PS_W-1:0] cnt;

    assign pulse = (cnt == '0);

    // Count down; reload the preset on the zero cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (pulse)  cnt <= preset;
        else             cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/tick_divider.sv
// Per-channel power-of-two divider that counts prescaler pulses and emits a
// registered one-cycle tick every 2^(code+DIV_BASE) pulses, saturated at
// 2^MAX_LOG2. A restart clears the phase and any pending tick.
// Assumes: restart coincides with the cycle the code register is written.
module tick_divider
    import tick_prescale_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 1,
    parameter int MAX_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             restart,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);

    logic [MAX_LOG2-1:0] phase;
    logic [MAX_LOG2:0]   last_phase;
    int                  lg;
    logic                wrap;

    // Work out the terminal phase from the code
    always_comb begin
        lg         = eff_log2(int'(code), DIV_BASE, MAX_LOG2);
        last_phase = (MAX_LOG2+1)'((1 << lg) - 1);
        wrap       = pulse && ({1'b0, phase} == last_phase);
    end

    // Advance the phase on each pulse, wrap at the terminal phase, tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap)       phase <= '0;
            else if (pulse) phase <= phase + 1'b1;
        end
    end

    // R7: a tick is a single cycle when the divisor exceeds one
    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lg != 0 && !restart) |=> !tick);

    // R4: a tick always follows a prescaler pulse
    p_tick_needs_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(pulse));

    // R8: a restart silences the tick in the next cycle
    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

    // R6: the phase never passes the saturated divisor
    p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, phase} <= last_phase || $past(restart) || $changed(code));

endmodule

// File: rtl/tick_prescale_bank.sv
// Top of the tick generator: configuration words, two shared prescalers and
// one divider per channel. Channels below SPLIT_CH use prescaler 0, the rest
// use prescaler 1. All outputs are enables in the clk domain.
// Assumes: REG_W covers both configuration words.
module tick_prescale_bank
    import tick_prescale_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int SPLIT_CH = 2,
    parameter int PS_W     = 8,
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 1,
    parameter int MAX_LOG2 = 4,
    parameter int REG_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] ch_tick
);

    localparam int PSW_ALL  = 2 * PS_W;
    localparam int SELW_ALL = NUM_CH * SEL_W;

    logic [PSW_ALL-1:0]  cfg_ps;
    logic [SELW_ALL-1:0] cfg_sel;
    logic [1:0]          ps_pulse;
    logic                sel_write;

    assign sel_write = reg_wr_en && (reg_addr == ADDR_DIVSEL);

    // Store the configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ps  <= '0;
            cfg_sel <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == ADDR_PRESCALE) cfg_ps  <= reg_wdata[PSW_ALL-1:0];
            else                           cfg_sel <= reg_wdata[SELW_ALL-1:0];
        end
    end

    // Return the addressed word, zero above its field
    always_comb begin
        if (reg_addr == ADDR_DIVSEL) reg_rdata = REG_W'(cfg_sel);
        else                         reg_rdata = REG_W'(cfg_ps);
    end

    for (genvar g = 0; g < 2; g++) begin : g_ps
        tick_prescaler #(.PS_W(PS_W)) u_ps (
            .clk    (clk),
            .rst_n  (rst_n),
            .preset (cfg_ps[g*PS_W +: PS_W]),
            .pulse  (ps_pulse[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tick_divider #(
            .SEL_W    (SEL_W),
            .DIV_BASE (DIV_BASE),
            .MAX_LOG2 (MAX_LOG2)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse   ((c < SPLIT_CH) ? ps_pulse[0] : ps_pulse[1]),
            .restart (sel_write),
            .code    (cfg_sel[c*SEL_W +: SEL_W]),
            .tick    (ch_tick[c])
        );
    end

    // R1: reset leaves every tick low at the next edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (ch_tick == '0));

endmodule

// File: tb/tick_prescale_bank_bench.sv
`timescale 1ns/1ps
module tick_prescale_bank_bench;

    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  ch_tick;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int p_cur [2];
    int c_cur [NCH];

    tick_prescale_bank u_tick_prescale_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_tick(ch_tick)
    );

    always #2.5 clk = ~clk;

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int exp_period(input int p, input int code);
        int lg;
        lg = code + 1;
        if (lg > 4) lg = 4;
        return (p + 1) * (1 << lg);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a) begin
            for (int c = 0; c < NCH; c++) c_cur[c] = int'(d[c*4 +: 4]);
        end else begin
            p_cur[0] = int'(d[7:0]); p_cur[1] = int'(d[15:8]);
        end
    endtask

    // Wait for a tick on channel ch, then return cycles to the next one
    task automatic gap(input int ch, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!ch_tick[ch] && n < 20000);
        n = 0;
        do begin @(negedge clk); n++; end while (!ch_tick[ch] && n < 20000);
    endtask

    task automatic check_period(input string req, input int ch);
        int n;
        int dummy;
        gap(ch, dummy);
        gap(ch, n);
        check(req, n, exp_period(p_cur[ch < 2 ? 0 : 1], c_cur[ch]));
    endtask

    initial begin
        int n;
        logic [31:0] w;
        void'($urandom(32'h1d2c_3b4a));
        p_cur[0] = 0; p_cur[1] = 0;
        for (int c = 0; c < NCH; c++) c_cur[c] = 0;

        // R1: ticks low during reset, words read zero after it
        repeat (3) @(negedge clk);
        check("R1 tick in reset", ch_tick, 0);
        @(negedge clk); rst_n = 1'b1;
        reg_addr = 1'b0; #0.1;
        check("R1 word0 after reset", reg_rdata, 0);
        reg_addr = 1'b1; #0.1;
        check("R1 word1 after reset", reg_rdata, 0);

        // R2: readback, upper bits read zero
        wr(1'b0, 32'hFFFF_A53C);
        reg_addr = 1'b0; #0.1;
        check("R2 word0 readback", reg_rdata, 32'h0000_A53C);
        wr(1'b1, 32'hFFF5_4321);
        reg_addr = 1'b1; #0.1;
        check("R2 word1 readback", reg_rdata, 32'h0005_4321);

        // R3 R5: smallest setting, period 2, and single-cycle tick (R7)
        wr(1'b0, 32'h0000_0000);
        wr(1'b1, 32'h0000_0000);
        check_period("R3 min period ch0", 0);
        @(negedge clk);
        check("R7 tick one cycle wide", ch_tick[0], 0);

        // R4: prescaler split between the two channel groups
        wr(1'b0, 32'h0000_0502);
        wr(1'b1, 32'h0000_0000);
        check_period("R4 ch1 uses prescaler0", 1);
        check_period("R4 ch2 uses prescaler1", 2);
        check_period("R4 ch4 uses prescaler1", 4);

        // R5: field offset per channel and base encoding
        wr(1'b1, 32'h0003_2100);
        check_period("R5 ch2 code1", 2);
        check_period("R5 ch3 code2", 3);
        check_period("R5 ch4 code3", 4);

        // R6: codes beyond the maximum saturate at divide-by-16
        wr(1'b0, 32'h0000_0101);
        wr(1'b1, 32'h000F_0F0F);
        check_period("R6 ch0 code15", 0);
        gap(0, n); gap(0, n);
        check("R6 ch0 saturated", n, 2 * 16);

        // R8: restart phase; first tick after a word-1 write within bounds
        wr(1'b0, 32'h0000_0303);
        wr(1'b1, 32'h0000_0011);
        repeat (7) @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0000_0011;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R8 no tick after write", ch_tick[0], 0);
        n = 1;
        while (!ch_tick[0] && n < 1000) begin @(negedge clk); n++; end
        check("R8 first tick not early", (n > 4 * 3) ? 1 : 0, 1);
        check("R8 first tick not late", (n <= 4 * 4 + 1) ? 1 : 0, 1);

        // R9: new prescaler value waits for the running countdown
        wr(1'b0, 32'h0000_0064);
        wr(1'b1, 32'h0000_0000);
        gap(0, n); gap(0, n);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0000_0000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        n = 1;
        while (!ch_tick[0] && n < 1000) begin @(negedge clk); n++; end
        check("R9 old countdown honoured", (n > 50) ? 1 : 0, 1);
        p_cur[0] = 0;

        // R3 R4 R5: random configurations
        for (int t = 0; t < 6; t++) begin
            w = {16'h0, 2'b0, 6'($urandom_range(0, 31)), 2'b0, 6'($urandom_range(0, 31))};
            wr(1'b0, w);
            w = {12'h0, 20'($urandom)};
            wr(1'b1, w);
            for (int c = 0; c < NCH; c++) check_period("R3 random period", c);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule